// File: doc/BRIEF.md
# DMA Interrupt Mask and Status Unit

This unit collects completion and error events for a multi-channel packet DMA engine and turns them into three interrupt lines: one for transmit channels, one for receive channels and one for engine-level faults. Each of the three groups keeps a raw status that tracks its event inputs. It also keeps a mask that software changes only through separate write-one-to-set and write-one-to-clear addresses. A masked status view is the bitwise AND of the two. Bit n of every transmit or receive register belongs to channel n. In the engine-level group, bit 1 is the host-error source.

Software reaches the unit through a plain 32-bit register port with a combinational read path. An end-of-interrupt write disarms the selected interrupt outputs. Each disarmed output stays low until a masked source shows a fresh rising edge, so one event never yields two service requests. Two single-bit control registers gate the transmit and receive directions of the engine. A soft-reset register runs a fixed-length internal reset. That reset wipes all masks and raw status, and the register reads back as nonzero until the reset finishes.

Top module: `dma_irq_unit`

## Requirements
- R1: After reset, every raw status, mask and masked status register reads 0. All three interrupt outputs and both direction enables are low, and the soft-reset register at 0x1C reads 0.
- R2: Raw status at 0x80 (transmit), 0xA0 (receive) and 0xB0 (engine) equals the matching event input vector as sampled at the previous clock edge. Bit n is channel n, and engine bit 1 is the host-error source.
- R3: A write to a mask-set address (0x88, 0xA8, 0xB8) sets the mask bits that are 1 in the write data. A write to a mask-clear address (0x8C, 0xAC, 0xBC) clears them. Zero bits leave the mask unchanged, and a read of either address returns the current mask.
- R4: Masked status at 0x84, 0xA4 and 0xB4 reads as raw status AND mask.
- R5: A group's interrupt output is high only while the group is armed and its masked status is nonzero. It is low whenever the group's mask is 0.
- R6: A write to 0x94 disarms each group whose bit is 1 in the write data (bit 0 transmit, bit 1 receive, bit 2 engine). A disarmed group re-arms one cycle after any of its masked bits goes from 0 to 1. A rising edge of an unmasked bit does not re-arm it, and a masked rising edge in the same cycle as the disarm write wins.
- R7: A write with bit 0 set to 0x1C starts a soft reset. The register reads 1 for SRST_CYCLES clock cycles after the write edge and then 0. A write with bit 0 clear has no effect.
- R8: While a soft reset runs, all masks and raw status are held at 0 and mask writes are ignored. Raw status resumes tracking the inputs once the reset ends.
- R9: Bit 0 of 0x04 drives the transmit enable output and bit 0 of 0x14 drives the receive enable output. Both read back and are not affected by soft reset.
- R10: Reads of unmapped addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_wr | input | 1 | Register write strobe |
| req_addr | input | ADDR_W | Byte address of the register access |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Read data for req_addr (combinational) |
| tx_evt | input | NUM_CH | Transmit channel event levels |
| rx_evt | input | NUM_CH | Receive channel event levels |
| dma_evt | input | DMA_SRC | Engine-level event levels, bit 1 host error |
| tx_irq | output | 1 | Transmit group interrupt |
| rx_irq | output | 1 | Receive group interrupt |
| dma_irq | output | 1 | Engine group interrupt |
| tx_en | output | 1 | Transmit direction enable |
| rx_en | output | 1 | Receive direction enable |

## Verification
On every cycle, the bound checker confirms several rules. An interrupt never rises with an empty mask. A set write leaves its bits set. A disarm without a coincident masked edge forces the output low on the next cycle. A running soft reset leaves masks and raw status at zero, and the reset never starts without a write. Only the bench's scenarios show the remaining behaviour. These are the exact length of the soft reset and the ignored mask write in its middle. They also include the two-cycle delay from event to re-arm, the refusal to re-arm on an unmasked edge, and the per-group selection of the disarm write.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   localparam int OFS_TX_CTL   = 'h04;
   localparam int OFS_RX_CTL   = 'h14;
   localparam int OFS_SRST     = 'h1C;
   localparam int OFS_TX_RAW   = 'h80;
   localparam int OFS_TX_MSK   = 'h84;
   localparam int OFS_TX_MSET  = 'h88;
   localparam int OFS_TX_MCLR  = 'h8C;
   localparam int OFS_EOI      = 'h94;
   localparam int OFS_RX_RAW   = 'hA0;
   localparam int OFS_RX_MSK   = 'hA4;
   localparam int OFS_RX_MSET  = 'hA8;
   localparam int OFS_RX_MCLR  = 'hAC;
   localparam int OFS_DMA_RAW  = 'hB0;
   localparam int OFS_DMA_MSK  = 'hB4;
   localparam int OFS_DMA_MSET = 'hB8;
   localparam int OFS_DMA_MCLR = 'hBC;

   // disarm select bits in the end-of-interrupt write data
   typedef enum int {GRP_TX = 0, GRP_RX = 1, GRP_DMA = 2} irq_grp_e;
endpackage

// File: rtl/dma_irq_group.sv
module dma_irq_group #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold_clr,
   input  logic [W-1:0] evt,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   input  logic         eoi,
   output logic [W-1:0] raw,
   output logic [W-1:0] mask,
   output logic [W-1:0] masked,
   output logic         rise_any,
   output logic         irq
);
   logic [W-1:0] masked_q;
   logic         armed;

   assign masked   = raw & mask;
   assign rise_any = |(masked & ~masked_q);
   assign irq      = armed & (|masked);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw      <= '0;
         mask     <= '0;
         masked_q <= '0;
         armed    <= 1'b1;
      end else begin
         masked_q <= masked;
         if (hold_clr) begin
            raw  <= '0;
            mask <= '0;
         end else begin
            raw <= evt;
            if (set_we)
               mask <= mask | wdata;
            else if (clr_we)
               mask <= mask & ~wdata;
         end
         if (rise_any)
            armed <= 1'b1;
         else if (eoi)
            armed <= 1'b0;
      end
   end
endmodule

// File: rtl/dma_srst_timer.sv
module dma_srst_timer #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(CYCLES + 1);

   generate
      if (CYCLES < 1) begin : g_bad_len
         $error("dma_srst_timer: CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign busy = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (start)
         cnt <= CW'(CYCLES);
      else if (busy)
         cnt <= cnt - 1'b1;
   end
endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH      = 8,
   parameter int DMA_SRC     = 2,
   parameter int SRST_CYCLES = 8,
   parameter int ADDR_W      = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_wr,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [31:0]        req_wdata,
   output logic [31:0]        req_rdata,
   input  logic [NUM_CH-1:0]  tx_evt,
   input  logic [NUM_CH-1:0]  rx_evt,
   input  logic [DMA_SRC-1:0] dma_evt,
   output logic               tx_irq,
   output logic               rx_irq,
   output logic               dma_irq,
   output logic               tx_en,
   output logic               rx_en
);
   generate
      if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_ch
         $error("dma_irq_unit: NUM_CH must be 1..32");
      end
      if (DMA_SRC < 2 || DMA_SRC > 32) begin : g_bad_src
         $error("dma_irq_unit: DMA_SRC must be 2..32");
      end
      if (ADDR_W < 8) begin : g_bad_aw
         $error("dma_irq_unit: ADDR_W must be at least 8");
      end
   endgenerate

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
      return a == ADDR_W'(ofs);
   endfunction

   logic               srst_busy;
   logic               srst_start;
   logic               eoi_wr;
   logic [NUM_CH-1:0]  tx_raw, tx_mask, tx_masked;
   logic [NUM_CH-1:0]  rx_raw, rx_mask, rx_masked;
   logic [DMA_SRC-1:0] dma_raw, dma_mask, dma_masked;
   logic               tx_rise, rx_rise, dma_rise;

   assign srst_start = req_wr && hit(req_addr, OFS_SRST) && req_wdata[0];
   assign eoi_wr     = req_wr && hit(req_addr, OFS_EOI);

   dma_srst_timer #(.CYCLES(SRST_CYCLES)) u_srst (
      .clk   (clk),
      .rst_n (rst_n),
      .start (srst_start),
      .busy  (srst_busy)
   );

   dma_irq_group #(.W(NUM_CH)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_clr (srst_busy),
      .evt      (tx_evt),
      .set_we   (req_wr && hit(req_addr, OFS_TX_MSET)),
      .clr_we   (req_wr && hit(req_addr, OFS_TX_MCLR)),
      .wdata    (req_wdata[NUM_CH-1:0]),
      .eoi      (eoi_wr && req_wdata[GRP_TX]),
      .raw      (tx_raw),
      .mask     (tx_mask),
      .masked   (tx_masked),
      .rise_any (tx_rise),
      .irq      (tx_irq)
   );

   dma_irq_group #(.W(NUM_CH)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_clr (srst_busy),
      .evt      (rx_evt),
      .set_we   (req_wr && hit(req_addr, OFS_RX_MSET)),
      .clr_we   (req_wr && hit(req_addr, OFS_RX_MCLR)),
      .wdata    (req_wdata[NUM_CH-1:0]),
      .eoi      (eoi_wr && req_wdata[GRP_RX]),
      .raw      (rx_raw),
      .mask     (rx_mask),
      .masked   (rx_masked),
      .rise_any (rx_rise),
      .irq      (rx_irq)
   );

   dma_irq_group #(.W(DMA_SRC)) u_dma (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_clr (srst_busy),
      .evt      (dma_evt),
      .set_we   (req_wr && hit(req_addr, OFS_DMA_MSET)),
      .clr_we   (req_wr && hit(req_addr, OFS_DMA_MCLR)),
      .wdata    (req_wdata[DMA_SRC-1:0]),
      .eoi      (eoi_wr && req_wdata[GRP_DMA]),
      .raw      (dma_raw),
      .mask     (dma_mask),
      .masked   (dma_masked),
      .rise_any (dma_rise),
      .irq      (dma_irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en <= 1'b0;
         rx_en <= 1'b0;
      end else if (req_wr) begin
         if (hit(req_addr, OFS_TX_CTL)) tx_en <= req_wdata[0];
         if (hit(req_addr, OFS_RX_CTL)) rx_en <= req_wdata[0];
      end
   end

   always_comb begin
      req_rdata = '0;
      if      (hit(req_addr, OFS_TX_CTL))   req_rdata = 32'(tx_en);
      else if (hit(req_addr, OFS_RX_CTL))   req_rdata = 32'(rx_en);
      else if (hit(req_addr, OFS_SRST))     req_rdata = 32'(srst_busy);
      else if (hit(req_addr, OFS_TX_RAW))   req_rdata = 32'(tx_raw);
      else if (hit(req_addr, OFS_TX_MSK))   req_rdata = 32'(tx_masked);
      else if (hit(req_addr, OFS_TX_MSET) || hit(req_addr, OFS_TX_MCLR))
         req_rdata = 32'(tx_mask);
      else if (hit(req_addr, OFS_RX_RAW))   req_rdata = 32'(rx_raw);
      else if (hit(req_addr, OFS_RX_MSK))   req_rdata = 32'(rx_masked);
      else if (hit(req_addr, OFS_RX_MSET) || hit(req_addr, OFS_RX_MCLR))
         req_rdata = 32'(rx_mask);
      else if (hit(req_addr, OFS_DMA_RAW))  req_rdata = 32'(dma_raw);
      else if (hit(req_addr, OFS_DMA_MSK))  req_rdata = 32'(dma_masked);
      else if (hit(req_addr, OFS_DMA_MSET) || hit(req_addr, OFS_DMA_MCLR))
         req_rdata = 32'(dma_mask);
   end
endmodule

// File: rtl/dma_irq_checks.sv
module dma_irq_checks
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH  = 8,
   parameter int DMA_SRC = 2,
   parameter int ADDR_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_wr,
   input logic [ADDR_W-1:0]  req_addr,
   input logic [31:0]        req_wdata,
   input logic [NUM_CH-1:0]  tx_raw,
   input logic [NUM_CH-1:0]  tx_mask,
   input logic [DMA_SRC-1:0] dma_mask,
   input logic               tx_rise,
   input logic               srst_busy,
   input logic               tx_irq,
   input logic               dma_irq,
   input logic               tx_en
);
   a_r5_tx_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_mask == '0) |-> !tx_irq);

   a_r5_dma_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_mask == '0) |-> !dma_irq);

   a_r3_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (req_wr && req_addr == ADDR_W'(OFS_TX_MSET) && !srst_busy)
      |=> ((tx_mask & $past(req_wdata[NUM_CH-1:0])) == $past(req_wdata[NUM_CH-1:0])));

   a_r6_eoi_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (req_wr && req_addr == ADDR_W'(OFS_EOI) && req_wdata[GRP_TX] && !tx_rise)
      |=> !tx_irq);

   a_r8_srst_wipes: assert property (@(posedge clk) disable iff (!rst_n)
      srst_busy |=> (tx_mask == '0 && tx_raw == '0 && dma_mask == '0));

   a_r7_no_spurious_srst: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst_busy && !(req_wr && req_addr == ADDR_W'(OFS_SRST) && req_wdata[0]))
      |=> !srst_busy);

   a_r9_tx_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (req_wr && req_addr == ADDR_W'(OFS_TX_CTL)) |=> (tx_en == $past(req_wdata[0])));
endmodule

bind dma_irq_unit dma_irq_checks #(
   .NUM_CH  (NUM_CH),
   .DMA_SRC (DMA_SRC),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_wr    (req_wr),
   .req_addr  (req_addr),
   .req_wdata (req_wdata),
   .tx_raw    (tx_raw),
   .tx_mask   (tx_mask),
   .dma_mask  (dma_mask),
   .tx_rise   (tx_rise),
   .srst_busy (srst_busy),
   .tx_irq    (tx_irq),
   .dma_irq   (dma_irq),
   .tx_en     (tx_en)
);

// File: tb/sim_dma_irq_unit.sv
module sim_dma_irq_unit;
   localparam int NUM_CH = 8;
   localparam int DMA_SRC = 2;
   localparam int SRST_CYCLES = 8;
   localparam int ADDR_W = 8;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               req_wr = 1'b0;
   logic [ADDR_W-1:0]  req_addr = '0;
   logic [31:0]        req_wdata = '0;
   logic [31:0]        req_rdata;
   logic [NUM_CH-1:0]  tx_evt = '0;
   logic [NUM_CH-1:0]  rx_evt = '0;
   logic [DMA_SRC-1:0] dma_evt = '0;
   logic               tx_irq, rx_irq, dma_irq, tx_en, rx_en;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dma_irq_unit #(
      .NUM_CH(NUM_CH), .DMA_SRC(DMA_SRC), .SRST_CYCLES(SRST_CYCLES), .ADDR_W(ADDR_W)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_rdata(req_rdata), .tx_evt(tx_evt),
      .rx_evt(rx_evt), .dma_evt(dma_evt), .tx_irq(tx_irq), .rx_irq(rx_irq),
      .dma_irq(dma_irq), .tx_en(tx_en), .rx_en(rx_en)
   );

   // {write, address, data}; for reads the data field is the expected value
   localparam logic [40:0] VEC [16] = '{
      {1'b1, 8'h88, 32'h0F}, {1'b0, 8'h88, 32'h0F}, {1'b0, 8'h8C, 32'h0F},
      {1'b1, 8'h8C, 32'h05}, {1'b0, 8'h88, 32'h0A}, {1'b1, 8'hA8, 32'hF0},
      {1'b0, 8'hAC, 32'hF0}, {1'b1, 8'hB8, 32'h02}, {1'b0, 8'hB8, 32'h02},
      {1'b1, 8'h04, 32'h01}, {1'b0, 8'h04, 32'h01}, {1'b1, 8'h14, 32'h01},
      {1'b0, 8'h14, 32'h01}, {1'b1, 8'h40, 32'hFF}, {1'b0, 8'h40, 32'h00},
      {1'b0, 8'h88, 32'h0A}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      req_wr = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_wr = 1'b0; req_wdata = '0;
   endtask

   task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
      req_addr = a;
      #1;
      check(tag, req_rdata, exp);
   endtask

   function automatic string vec_tag(input logic [7:0] a);
      if (a == 8'h04 || a == 8'h14) return "R9";
      if (a == 8'h40) return "R10";
      return "R3";
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd("R1", 8'h80, 0);
      rd("R1", 8'h88, 0);
      rd("R1", 8'hB4, 0);
      rd("R1", 8'h1C, 0);
      check("R1", {tx_irq, rx_irq, dma_irq, tx_en, rx_en}, 0);

      for (int i = 0; i < 16; i++) begin
         if (VEC[i][40]) wr(VEC[i][39:32], VEC[i][31:0]);
         else rd(vec_tag(VEC[i][39:32]), VEC[i][39:32], VEC[i][31:0]);
      end
      check("R9", {tx_en, rx_en}, 2'b11);

      // R2 / R4 / R5: transmit events with mask 0x0A
      tx_evt = 8'h33;
      @(negedge clk);
      rd("R2", 8'h80, 32'h33);
      rd("R4", 8'h84, 32'h02);
      check("R5", tx_irq, 1'b1);
      check("R5", rx_irq, 1'b0);

      // R6 disarm transmit only
      rx_evt = 8'h10;
      @(negedge clk);
      check("R5", rx_irq, 1'b1);
      wr(8'h94, 32'h1);
      check("R6", tx_irq, 1'b0);
      check("R6", rx_irq, 1'b1);
      // unmasked edge (bit 2) does not re-arm
      tx_evt = 8'h37;
      repeat (2) @(negedge clk);
      check("R6", tx_irq, 1'b0);
      // masked edge (bit 3) re-arms one cycle after it shows in status
      tx_evt = 8'h3F;
      @(negedge clk);
      check("R6", tx_irq, 1'b0);
      @(negedge clk);
      check("R6", tx_irq, 1'b1);

      // R2 / R4 engine host error on bit 1
      dma_evt = 2'b10;
      @(negedge clk);
      rd("R2", 8'hB0, 32'h2);
      rd("R4", 8'hB4, 32'h2);
      check("R5", dma_irq, 1'b1);

      // R7 / R8 soft reset
      wr(8'h1C, 32'h1);
      rd("R7", 8'h1C, 1);
      @(negedge clk);
      rd("R7", 8'h1C, 1);
      rd("R8", 8'h88, 0);
      rd("R8", 8'h80, 0);
      check("R8", {tx_irq, rx_irq, dma_irq}, 0);
      wr(8'h88, 32'hFF);
      rd("R8", 8'h88, 0);
      check("R9", {tx_en, rx_en}, 2'b11);
      for (int k = 3; k <= SRST_CYCLES - 1; k++) begin
         @(negedge clk);
         rd("R7", 8'h1C, 1);
      end
      @(negedge clk);
      rd("R7", 8'h1C, 0);
      @(negedge clk);
      rd("R8", 8'h80, 32'h3F);
      check("R5", tx_irq, 1'b0);

      // R7 write of zero does nothing
      wr(8'h1C, 32'h0);
      rd("R7", 8'h1C, 0);
      wr(8'h04, 32'h0);
      check("R9", tx_en, 1'b0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule